// File: doc/BRIEF.md
# Flag-Driven Conditional Operand Select

This block picks one of two data operands according to a four-bit condition code evaluated against the arithmetic flags held in a status word. The negative, zero, carry and overflow flags are read from the top four bits of the status word. The condition code names one of sixteen tests:

- single-flag tests,
- unsigned magnitude comparisons built from carry and zero,
- signed comparisons built from negative, overflow and zero,
- two codes that always pass.

When the test passes, the "then" operand reaches the result. When it fails, the "else" operand does.

The operand width is a parameter, normally 32 or 64 bits. The pass/fail decision is the same at every width. A second parameter adds one register stage after the multiplexer for timing closure. That stage has a synchronous, active-high reset that clears it. With the parameter off, the block is purely combinational and the clock and reset only serve the checks.

Top module: `csel_top`

## Requirements
- R1: The flags are negative = status_word[31], zero = status_word[30], carry = status_word[29], overflow = status_word[28]; status_word bits 27:0 have no effect on result.
- R2: Code 0 passes when zero is 1; code 1 passes when zero is 0.
- R3: Code 2 passes when carry is 1; code 3 passes when carry is 0.
- R4: Code 4 passes when negative is 1; code 5 passes when negative is 0.
- R5: Code 6 passes when overflow is 1; code 7 passes when overflow is 0.
- R6: Code 8 passes when carry is 1 and zero is 0; code 9 passes when carry is 0 or zero is 1.
- R7: Code 10 passes when negative equals overflow; code 11 passes when they differ.
- R8: Code 12 passes when zero is 0 and negative equals overflow; code 13 passes when zero is 1 or negative differs from overflow.
- R9: Codes 14 and 15 always pass, whatever the flags.
- R10: result equals then_op when the selected test passes and else_op when it fails.
- R11: With REG_OUT=1, result shows the selection for the inputs present at the previous rising clock edge and stays unchanged between edges. A clock edge with rst high clears result to zero.
- R12: The pass/fail decision does not depend on DATA_W; 32-bit and 64-bit builds select identically for the same flags and code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| status_word | input | STATUS_W | Status word; flags in bits 31:28 |
| cond_code | input | 4 | Condition to evaluate, encoded 0 to 15 |
| then_op | input | DATA_W | Operand selected when the condition passes |
| else_op | input | DATA_W | Operand selected when the condition fails |
| result | output | DATA_W | Selected operand, registered when REG_OUT=1 |

## Verification
The bench instantiates two copies of the block side by side:

- a 64-bit copy with the output register enabled;
- a 32-bit combinational copy.

Both receive the same code, flags and (truncated) operands, so every one of the 256 code/flag pairs is judged at both widths. This also exposes the one-cycle latency and reset clearing of the registered variant. The lower 28 status bits are filled with fresh random values on every vector, which shows they never steer the choice. The "else" operand is always the bitwise complement of the "then" operand, so every wrong pick is visible in every bit.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // Flag positions inside the status word
    localparam int FLAG_NEG_POS = 31;
    localparam int FLAG_ZRO_POS = 30;
    localparam int FLAG_CRY_POS = 29;
    localparam int FLAG_OVF_POS = 28;
    localparam int FLAG_MSB_NEED = 32;
    localparam int COND_W = 4;

    typedef enum logic [COND_W-1:0] {
        CC_ZSET   = 4'd0,
        CC_ZCLR   = 4'd1,
        CC_CSET   = 4'd2,
        CC_CCLR   = 4'd3,
        CC_NSET   = 4'd4,
        CC_NCLR   = 4'd5,
        CC_VSET   = 4'd6,
        CC_VCLR   = 4'd7,
        CC_UGT    = 4'd8,
        CC_ULE    = 4'd9,
        CC_SGE    = 4'd10,
        CC_SLT    = 4'd11,
        CC_SGT    = 4'd12,
        CC_SLE    = 4'd13,
        CC_ALWAYS = 4'd14,
        CC_ALWAYX = 4'd15
    } cond_e;

    typedef struct packed {
        logic neg;
        logic zro;
        logic cry;
        logic ovf;
    } flags_t;

    // Pair index: codes come in pass/fail pairs, code[0] inverts the base test
    typedef enum logic [2:0] {
        PR_ZERO  = 3'd0,
        PR_CARRY = 3'd1,
        PR_NEG   = 3'd2,
        PR_OVF   = 3'd3,
        PR_UHIGH = 3'd4,
        PR_SGEQ  = 3'd5,
        PR_SGTR  = 3'd6,
        PR_ANY   = 3'd7
    } pair_e;

    function automatic logic pair_base(input pair_e p, input flags_t f);
        logic same_sign;
        same_sign = ~(f.neg ^ f.ovf);
        case (p)
            PR_ZERO:  pair_base = f.zro;
            PR_CARRY: pair_base = f.cry;
            PR_NEG:   pair_base = f.neg;
            PR_OVF:   pair_base = f.ovf;
            PR_UHIGH: pair_base = f.cry & ~f.zro;
            PR_SGEQ:  pair_base = same_sign;
            PR_SGTR:  pair_base = ~f.zro & same_sign;
            default:  pair_base = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/csel_flag_extract.sv
module csel_flag_extract
    import csel_pkg::*;
#(
    parameter int STATUS_W = 32
) (
    input  logic [STATUS_W-1:0] status_i,
    output flags_t              flags_o
);
    localparam int LOW_W = FLAG_OVF_POS;

    logic unused_low_bits;

    assign flags_o.neg = status_i[FLAG_NEG_POS];
    assign flags_o.zro = status_i[FLAG_ZRO_POS];
    assign flags_o.cry = status_i[FLAG_CRY_POS];
    assign flags_o.ovf = status_i[FLAG_OVF_POS];

    generate
        if (STATUS_W > FLAG_MSB_NEED) begin : g_wide
            assign unused_low_bits = ^{status_i[STATUS_W-1:FLAG_MSB_NEED], status_i[LOW_W-1:0]};
        end else begin : g_exact
            assign unused_low_bits = ^status_i[LOW_W-1:0];
        end
    endgenerate

    initial begin
        if (STATUS_W < FLAG_MSB_NEED) $error("status word too narrow for flags");
    end
endmodule

// File: rtl/csel_cond_eval.sv
module csel_cond_eval
    import csel_pkg::*;
(
    input  flags_t              flags_i,
    input  logic [COND_W-1:0]   code_i,
    output logic                pass_o
);
    pair_e pair;
    logic  base;
    logic  invert;

    always_comb begin
        pair   = pair_e'(code_i[COND_W-1:1]);
        base   = pair_base(pair, flags_i);
        // The last pair passes on both codes, so no inversion there
        invert = code_i[0] & (pair != PR_ANY);
        pass_o = base ^ invert;
    end
endmodule

// File: rtl/csel_operand_mux.sv
module csel_operand_mux #(
    parameter int DATA_W  = 32,
    parameter int SLICE_W = 8
) (
    input  logic              pass_i,
    input  logic [DATA_W-1:0] then_i,
    input  logic [DATA_W-1:0] else_i,
    output logic [DATA_W-1:0] sel_o
);
    localparam int NSLICE = (DATA_W + SLICE_W - 1) / SLICE_W;

    genvar gi;
    generate
        for (gi = 0; gi < NSLICE; gi++) begin : g_slice
            localparam int LO = gi * SLICE_W;
            localparam int HI = ((gi + 1) * SLICE_W > DATA_W) ? DATA_W - 1 : (gi + 1) * SLICE_W - 1;
            assign sel_o[HI:LO] = pass_i ? then_i[HI:LO] : else_i[HI:LO];
        end
    endgenerate
endmodule

// File: rtl/csel_top.sv
module csel_top
    import csel_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int STATUS_W = 32,
    parameter bit REG_OUT  = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [STATUS_W-1:0] status_word,
    input  logic [COND_W-1:0]   cond_code,
    input  logic [DATA_W-1:0]   then_op,
    input  logic [DATA_W-1:0]   else_op,
    output logic [DATA_W-1:0]   result
);
    flags_t            flags;
    logic              pass;
    logic [DATA_W-1:0] picked;

    csel_flag_extract #(.STATUS_W(STATUS_W)) u_flags (
        .status_i (status_word),
        .flags_o  (flags)
    );

    csel_cond_eval u_eval (
        .flags_i (flags),
        .code_i  (cond_code),
        .pass_o  (pass)
    );

    csel_operand_mux #(.DATA_W(DATA_W)) u_mux (
        .pass_i (pass),
        .then_i (then_op),
        .else_i (else_op),
        .sel_o  (picked)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic [DATA_W-1:0] res_q;
            always_ff @(posedge clk) begin
                if (rst) res_q <= '0;
                else     res_q <= picked;
            end
            assign result = res_q;

            // R11: first edge after reset shows the cleared register
            a_r11_reset_clear: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> result == '0);
            // R9: always-pass codes deliver the then operand one cycle later
            a_r9_always_then: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(cond_code) >= 4'd14) |-> result == $past(then_op));
            // R2: zero-set code with zero flag high picks then operand
            a_r2_zero_then: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(cond_code) == 4'd0 && $past(status_word[FLAG_ZRO_POS]))
                |-> result == $past(then_op));
            // R10: output is always one of the two operands seen last edge
            a_r10_one_of_two: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (result == $past(then_op) || result == $past(else_op)));
            // R6: unsigned-higher fails when carry is clear
            a_r6_uhigh_fail: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(cond_code) == 4'd8 && !$past(status_word[FLAG_CRY_POS]))
                |-> result == $past(else_op));
        end else begin : g_comb
            assign result = picked;

            // R9
            a_r9_always_then: assert property (@(posedge clk) disable iff (rst)
                cond_code >= 4'd14 |-> result == then_op);
            // R2
            a_r2_zero_then: assert property (@(posedge clk) disable iff (rst)
                (cond_code == 4'd0 && status_word[FLAG_ZRO_POS]) |-> result == then_op);
            // R10
            a_r10_one_of_two: assert property (@(posedge clk) disable iff (rst)
                result == then_op || result == else_op);
            // R6
            a_r6_uhigh_fail: assert property (@(posedge clk) disable iff (rst)
                (cond_code == 4'd8 && !status_word[FLAG_CRY_POS]) |-> result == else_op);
        end
    endgenerate
endmodule

// File: tb/sim_csel_top.sv
module sim_csel_top;
    localparam int CLK_PERIOD = 10;
    localparam int W64 = 64;
    localparam int W32 = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [31:0]     status_word = '0;
    logic [3:0]      cond_code = '0;
    logic [W64-1:0]  then64 = '0;
    logic [W64-1:0]  else64 = '0;
    logic [W64-1:0]  res64;
    logic [W32-1:0]  res32;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csel_top #(.DATA_W(W64), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .status_word(status_word), .cond_code(cond_code),
        .then_op(then64), .else_op(else64), .result(res64));

    csel_top #(.DATA_W(W32), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst(rst), .status_word(status_word), .cond_code(cond_code),
        .then_op(then64[W32-1:0]), .else_op(else64[W32-1:0]), .result(res32));

    // Reference: flags given as {n,z,c,v}
    function automatic bit ref_pass(input logic [3:0] code, input logic [3:0] f);
        bit n, z, c, v;
        {n, z, c, v} = f;
        case (code)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;
            4'd9:  return !c || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic string req_tag(input logic [3:0] code);
        case (code)
            4'd0, 4'd1:   return "R2";
            4'd2, 4'd3:   return "R3";
            4'd4, 4'd5:   return "R4";
            4'd6, 4'd7:   return "R5";
            4'd8, 4'd9:   return "R6";
            4'd10, 4'd11: return "R7";
            4'd12, 4'd13: return "R8";
            default:      return "R9";
        endcase
    endfunction

    task automatic check64(input string tag, input logic [W64-1:0] act, input logic [W64-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [W64-1:0] prev_exp64;

    task automatic apply(input logic [3:0] code, input logic [3:0] f, input logic [27:0] junk);
        logic [W64-1:0] t;
        logic [W64-1:0] e64;
        bit p;
        @(negedge clk);
        t = {$urandom(), $urandom()};
        cond_code   = code;
        status_word = {f, junk};
        then64      = t;
        else64      = ~t;
        p   = ref_pass(code, f);
        e64 = p ? t : ~t;
        #1;
        // R10/R12 and per-code requirement on the 32-bit combinational copy; R1 via random low bits
        check64({req_tag(code), " R10 R12 R1 comb32"}, {32'h0, res32}, {32'h0, e64[W32-1:0]});
        // R11: registered copy has not moved yet
        check64("R11 hold before edge", res64, prev_exp64);
        @(posedge clk);
        #1;
        check64({req_tag(code), " R10 R12 reg64"}, res64, e64);
        prev_exp64 = e64;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset clears the registered result
        check64("R11 reset state", res64, '0);
        @(negedge clk);
        rst = 1'b0;
        prev_exp64 = '0;
        // Exhaustive sweep: every code against every flag combination
        for (int code = 0; code < 16; code++) begin
            for (int f = 0; f < 16; f++) begin
                apply(4'(code), 4'(f), 28'($urandom()));
            end
        end
        // R1: extreme low-bit patterns must not change the choice
        apply(4'd0, 4'b0000, 28'hFFFFFFF);
        apply(4'd0, 4'b0100, 28'h0000000);
        apply(4'd11, 4'b1000, 28'hAAAAAAA);
        // R11: reset mid-run clears again
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check64("R11 reset mid-run", res64, '0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule